// File: doc/BRIEF.md
# Time-Slot Shared-Bus Packet Switch

This block is an N by N packet switch that routes purely by time position. One clock runs at the fast bit rate. An internal phase counter divides it into slow periods of exactly N fast cycles each, and every input line carries one bit per slow period. The input lines are sampled in the last fast cycle of each slow period.

Each input controller starts in programming mode. It collects a log2(N)-bit destination address serially, most significant bit first, one bit per slow period. A shared load strobe then copies the address into a modulo-N counter and puts the controller in counting mode. In counting mode the controller buffers one payload bit per slow period. The counter's carry falls in the fast cycle whose phase equals the destination address, and that carry releases the buffered bit into a merging tree that has one register stage per level.

The tree root feeds a serial-to-parallel register. That register is copied to the N outputs once per slow period, delayed by log2(N) fast cycles to cover the time a bit needs to cross the tree. After its fixed number of payload bits, a controller goes back to programming mode by itself. A complete set of packets with distinct destinations therefore needs no arbitration.

Top module: `tdsw_switch`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `par_o` is all zeros. The first cycle after reset has fast phase 0. Every controller leaves reset in programming mode with no pending bit, including a controller that was in the middle of a packet.
- R2: A slow period is exactly N fast cycles, phases 0 to N-1. `ser_i` and `load_i` are sampled only in the phase N-1 cycle.
- R3: In programming mode, each slow period shifts that input's `ser_i` bit into its address register. The first bit received becomes the most significant address bit, and log2(N) periods form a full address.
- R4: A slow period in programming mode with `load_i` high copies the address into the counter and enters counting mode. `ser_i` is ignored in that period.
- R5: In counting mode the controller takes exactly PLEN payload bits, one per slow period, beginning in the period right after the load period.
- R6: A payload bit from an input whose address is d appears on `par_o[d]`. An output with no bit routed to it in a given slot reads 0.
- R7: A payload bit sampled in slow period P is on `par_o` from phase log2(N) of period P+2 through phase log2(N)-1 of period P+3. `par_o` changes only at the end of the phase log2(N)-1 cycle.
- R8: After its last payload bit a controller returns to programming mode by itself. The next packet's address may begin in the very next slow period.
- R9: When the N inputs carry a permutation of the N addresses, all N streams are delivered at once, and at most one controller releases a bit in any fast cycle.
- R10: `load_i` has no effect while a controller is in counting mode. The payload bits are still taken and routed as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Shared strobe that moves each collected address into its counter |
| ser_i | input | N | One serial line per input: address bits, then payload bits |
| par_o | output | N | Registered parallel outputs, one bit per destination per slow period |

## Verification
A payload bit sampled at the end of slow period P is released in period P+1 at the phase equal to its address. It then crosses log2(N) tree registers, and `par_o` takes it at the end of phase log2(N)-1 of period P+2. At the first fast cycle of period k the bench compares `par_o` against the payload it drove in period k-3. After log2(N) fast cycles of period k it compares against the payload from period k-2, which brackets the single update point inside the period. Idle slots, load periods and periods after reset are expected to read zero.

// File: rtl/tdsw_pkg.sv
package tdsw_pkg;
  // One slot travelling through the concentrator: presence flag plus bit.
  typedef struct packed {
    logic vld;
    logic dat;
  } slot_t;

  function automatic slot_t slot_merge(slot_t a, slot_t b);
    slot_t r;
    r.vld = a.vld | b.vld;
    r.dat = (a.vld & a.dat) | (b.vld & b.dat);
    return r;
  endfunction
endpackage

// File: rtl/tdsw_phase.sv
module tdsw_phase #(
  parameter int N = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ph,
  output logic          tick
);
  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph + 1'b1;
  end

  // Last fast cycle of a slow period: inputs are sampled here.
  assign tick = (ph == PW'(N - 1));
endmodule

// File: rtl/tdsw_inctl.sv
module tdsw_inctl #(
  parameter int N    = 4,
  parameter int PLEN = 4,
  localparam int AW  = $clog2(N),
  localparam int RW  = $clog2(PLEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  logic ser,
  output logic rel_vld,
  output logic rel_dat
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] cnt_q;
  logic [RW-1:0] rem_q;
  logic          pend_q;
  logic          hold_q;
  logic [AW:0]   shifted;
  logic          prog;
  logic          carry;

  assign shifted = {addr_q, ser};
  assign prog    = (rem_q == '0);
  assign carry   = (cnt_q == AW'(N - 1));
  assign rel_vld = carry & pend_q;
  assign rel_dat = carry & pend_q & hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (rel_vld) pend_q <= 1'b0;
      if (tick) begin
        if (prog) begin
          if (load) begin
            // Preset so the carry lands on phase == address next period.
            cnt_q <= AW'(N - 1) - addr_q;
            rem_q <= RW'(PLEN);
          end else begin
            addr_q <= shifted[AW-1:0];
          end
        end else begin
          hold_q <= ser;
          pend_q <= 1'b1;
          rem_q  <= rem_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdsw_tree.sv
module tdsw_tree #(
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    leaf_vld,
  input  logic [N-1:0]    leaf_dat,
  output tdsw_pkg::slot_t root
);
  import tdsw_pkg::*;

  for (genvar l = 0; l < AW; l++) begin : g_lv
    localparam int W = N >> (l + 1);
    logic [2*W-1:0] cv;
    logic [2*W-1:0] cd;
    logic [W-1:0]   v_q;
    logic [W-1:0]   d_q;

    if (l == 0) begin : g_src
      assign cv = leaf_vld;
      assign cd = leaf_dat;
    end else begin : g_src
      assign cv = g_lv[l-1].v_q;
      assign cd = g_lv[l-1].d_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= '0;
        d_q <= '0;
      end else begin
        for (int k = 0; k < W; k++) begin
          slot_t m;
          m = slot_merge(slot_t'({cv[2*k], cd[2*k]}),
                         slot_t'({cv[2*k+1], cd[2*k+1]}));
          v_q[k] <= m.vld;
          d_q[k] <= m.dat;
        end
      end
    end
  end

  assign root.vld = g_lv[AW-1].v_q[0];
  assign root.dat = g_lv[AW-1].d_q[0];
endmodule

// File: rtl/tdsw_s2p.sv
module tdsw_s2p #(
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ph,
  input  tdsw_pkg::slot_t root,
  output logic [N-1:0]    par
);
  logic [N-2:0] sreg_q;
  logic [N-1:0] nxt;
  logic         flush;

  assign nxt   = {root.vld & root.dat, sreg_q};
  // Flush log2(N) cycles after the slow boundary, when the last slot lands.
  assign flush = (ph == AW'(AW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      par    <= '0;
    end else begin
      sreg_q <= nxt[N-1:1];
      if (flush) par <= nxt;
    end
  end
endmodule

// File: rtl/tdsw_switch.sv
module tdsw_switch #(
  parameter int N    = 4,
  parameter int PLEN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N-1:0] ser_i,
  output logic [N-1:0] par_o
);
  localparam int AW = $clog2(N);

  logic [AW-1:0]   ph;
  logic            tick;
  logic [N-1:0]    leaf_vld;
  logic [N-1:0]    leaf_dat;
  tdsw_pkg::slot_t root;

  tdsw_phase #(.N(N)) u_phase (
    .clk(clk), .rst(rst), .ph(ph), .tick(tick)
  );

  for (genvar i = 0; i < N; i++) begin : g_in
    tdsw_inctl #(.N(N), .PLEN(PLEN)) u_ctl (
      .clk(clk), .rst(rst), .tick(tick), .load(load_i), .ser(ser_i[i]),
      .rel_vld(leaf_vld[i]), .rel_dat(leaf_dat[i])
    );
  end

  tdsw_tree #(.N(N)) u_tree (
    .clk(clk), .rst(rst), .leaf_vld(leaf_vld), .leaf_dat(leaf_dat), .root(root)
  );

  tdsw_s2p #(.N(N)) u_s2p (
    .clk(clk), .rst(rst), .ph(ph), .root(root), .par(par_o)
  );
endmodule

// File: rtl/tdsw_switch_chk.sv
module tdsw_switch_chk #(
  parameter int N = 4,
  localparam int AW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ph,
  input logic [N-1:0]  leaf_vld,
  input logic [N-1:0]  par_o
);
  // R1: reset clears outputs and the phase.
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (par_o == '0) && (ph == '0));

  // R2: a slow period closes after phase N-1.
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (ph == AW'(N - 1)) |=> (ph == '0));

  // R7: outputs move only after the flush phase.
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (ph != AW'(AW - 1)) |=> $stable(par_o));

  // R9: contention-free slots, at most one release per fast cycle.
  a_r9_one_release: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leaf_vld));
endmodule

bind tdsw_switch tdsw_switch_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .ph(ph), .leaf_vld(leaf_vld), .par_o(par_o)
);

// File: tb/tdsw_switch_tb.sv
module tdsw_switch_tb;
  localparam int N    = 4;
  localparam int PLEN = 4;
  localparam int AW   = 2;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 5;

  // Destination of input i at [i*AW +: AW]; payload bit j of input i at [i*PLEN+j].
  localparam logic [N*AW-1:0]   DEST_T [NV] = '{8'hE4, 8'h1B, 8'hB1, 8'h4E, 8'h39};
  localparam logic [N*PLEN-1:0] PAY_T  [NV] = '{16'hA5C3, 16'h3C96, 16'hF00F, 16'h5A69, 16'hFFFF};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [N-1:0] ser_i = '0;
  logic [N-1:0] par_o;

  int nchk = 0;
  int nerr = 0;
  int pc = 0;
  bit done = 1'b0;
  string cur_tag = "R6";
  logic [N-1:0] exp_a [0:255];

  tdsw_switch #(.N(N), .PLEN(PLEN)) u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .ser_i(ser_i), .par_o(par_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] expv, input int p);
    nchk++;
    if (got !== expv) begin
      nerr++;
      $display("FAIL %s period %0d got %b exp %b", tag, p, got, expv);
    end
  endtask

  function automatic logic [N-1:0] expv_at(input int q);
    return (q < 0) ? '0 : exp_a[q];
  endfunction

  // One slow period, entered at a falling edge: phase 0 starts here.
  task automatic period(input logic ld, input logic [N-1:0] bits, input logic [N-1:0] ev);
    exp_a[pc] = ev;
    check(cur_tag, par_o, expv_at(pc - 3), pc);      // R7: still the old flush
    load_i = ld;
    ser_i  = bits;
    repeat (AW) @(negedge clk);
    check("R7 update", par_o, expv_at(pc - 2), pc);  // R7: updated after phase AW-1
    repeat (N - AW) @(negedge clk);
    pc++;
  endtask

  // R3 address MSB first, R4 load period with ser ignored, R5 payload periods.
  task automatic run_set(input logic [N*AW-1:0] dv, input logic [N*PLEN-1:0] pv,
                         input logic ld_in_pay);
    logic [N-1:0] bits;
    logic [N-1:0] ev;
    for (int j = 0; j < AW; j++) begin
      for (int i = 0; i < N; i++) bits[i] = dv[i*AW + (AW - 1 - j)];
      period(1'b0, bits, '0);
    end
    period(1'b1, '1, '0);
    for (int j = 0; j < PLEN; j++) begin
      ev = '0;
      for (int i = 0; i < N; i++) begin
        bits[i] = pv[i*PLEN + j];
        ev[dv[i*AW +: AW]] = bits[i];
      end
      period(ld_in_pay, bits, ev);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) period(1'b0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", par_o, '0, -1);
    rst = 1'b0;
    pc  = 0;

    // Table walk: permutations back to back (R2 R3 R4 R5 R6 R8 R9).
    cur_tag = "R6 R8 R9";
    for (int v = 0; v < NV; v++) run_set(DEST_T[v], PAY_T[v], 1'b0);
    cur_tag = "R6 idle";
    idle(4);

    // R10: load held high through every payload period.
    cur_tag = "R10";
    run_set(DEST_T[1], PAY_T[2], 1'b1);
    idle(4);

    // R1: reset in the middle of a packet, then a fresh packet.
    cur_tag = "R1 mid";
    for (int j = 0; j < AW; j++) period(1'b0, '1, '0);
    period(1'b1, '0, '0);
    period(1'b0, 4'b1011, '0);
    rst = 1'b1;
    load_i = 1'b0;
    ser_i = '0;
    repeat (2) @(negedge clk);
    check("R1 after reset", par_o, '0, -1);
    rst = 1'b0;
    pc  = 0;
    cur_tag = "R1 R8";
    run_set(DEST_T[3], PAY_T[0], 1'b0);
    run_set(DEST_T[4], PAY_T[3], 1'b0);
    idle(4);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule